// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Timer

This block decides when the power switch of a quasi-resonant flyback converter is turned on again. It sees the sync waveform only through two digital flags. One says the sync level is still on its high plateau (above about 4.4 V). The other is a hysteretic comparator whose 1-to-0 transition marks a resonant valley. All timing is counted in clock cycles of the block's time base.

Every switching period begins with a cycle-start pulse. A blanking interval follows, during which no turn-on may happen. At the last blanking cycle the block chooses a path. If sync is still high, a short fixed delay follows and then the switch turns on; this is the heavy-load path. Otherwise the block searches a bounded window for the first or second valley, turns on a fixed delay after that valley, and forces a turn-on when the window closes with no qualifying valley. The turn-on request is a one-cycle pulse. Each turn-on also starts the next period.

Top module: `qr_valley_timer`

## Requirements
- R1: While reset is high or enable is low, gate_on_o and cycle_start_o stay 0 and every timer is held cleared.
- R2: The first clock edge that samples enable high after a period of disable or reset makes cycle_start_o pulse for one cycle with gate_on_o low, and a new period begins there.
- R3: No gate_on_o pulse occurs within BLANK_CYC clock cycles of the cycle_start_o pulse that opened the period.
- R4: With sync_high_i low at the decision edge (BLANK_CYC cycles after the period start), a valley is a clock edge that samples sync_cmp_i = 0 after sampling 1 on the previous edge. For a valley at window position j (1..WIN_CYC), gate_on_o pulses BLANK_CYC + j + VDLY_CYC cycles after the period start.
- R5: Falling edges of sync_cmp_i sampled during blanking do not count as valleys.
- R6: If no qualifying valley arrives in the WIN_CYC window cycles, gate_on_o pulses BLANK_CYC + WIN_CYC cycles after the period start.
- R7: If sync_high_i is 1 at the decision edge, gate_on_o pulses BLANK_CYC + FLAT_CYC cycles after the period start, whatever sync_cmp_i does.
- R8: second_valley_i = 0 turns on at the first valley of the window; second_valley_i = 1 turns on at the second one and ignores the first.
- R9: gate_on_o is always a single-cycle pulse, and each one coincides with a cycle_start_o pulse.
- R10: A valley in the last window cycle (j = WIN_CYC) takes priority over the forced turn-on, giving a period of BLANK_CYC + WIN_CYC + VDLY_CYC.
- R11: Dropping enable in mid-period abandons that period with no pulse. The next enable starts a fresh period as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Switching enable; low holds the block idle |
| sync_high_i | input | 1 | Sync level is on its high plateau |
| sync_cmp_i | input | 1 | Hysteretic valley comparator; 1-to-0 marks a valley |
| second_valley_i | input | 1 | 0: first valley, 1: second valley |
| gate_on_o | output | 1 | One-cycle turn-on request |
| cycle_start_o | output | 1 | One-cycle pulse at the start of each period |

## Verification
The assertions check, on every cycle, the properties that hold for any stimulus. The gate pulse lasts one cycle and coincides with a period start, nothing fires while disabled, and no turn-on falls inside blanking or after the longest permitted period. The exact period for each path depends on the sync input pattern, so only the bench's scenarios can show it. These cover a valley at a given window position, a forced turn-on, the flat-sync path, second-valley selection, edges during blanking, a valley on the last window cycle, and a period abandoned through enable.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BLANK,
        PH_SEARCH,
        PH_VDLY,
        PH_FLAT
    } qrv_phase_e;

    // next-state decision of the sequencer for one cycle
    typedef struct packed {
        qrv_phase_e next;
        logic       restart;
        logic       fire;
        logic       start;
    } qrv_step_t;

    function automatic int unsigned qrv_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qrv_phase_timer.sv
module qrv_phase_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             flush_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (flush_i || restart_i) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    // last cycle of the current phase
    assign done_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/qrv_valley_det.sv
module qrv_valley_det (
    input  logic clk_i,
    input  logic flush_i,
    input  logic arm_i,
    input  logic cmp_i,
    input  logic second_i,
    output logic hit_o
);
    logic prev_q;
    logic seen_q;
    logic fall;

    assign fall  = prev_q & ~cmp_i;
    assign hit_o = arm_i & fall & (second_i ? seen_q : 1'b1);

    always_ff @(posedge clk_i) begin
        if (flush_i) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= cmp_i;
            if (!arm_i)                   seen_q <= 1'b0;
            else if (fall && !hit_o)      seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer
    import qrv_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 15,
    parameter int unsigned WIN_CYC   = 6,
    parameter int unsigned VDLY_CYC  = 1,
    parameter int unsigned FLAT_CYC  = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic sync_high_i,
    input  logic sync_cmp_i,
    input  logic second_valley_i,
    output logic gate_on_o,
    output logic cycle_start_o
);
    localparam int unsigned LONG_PH = qrv_max(qrv_max(BLANK_CYC, WIN_CYC),
                                              qrv_max(VDLY_CYC, FLAT_CYC));
    localparam int unsigned CNT_W   = $clog2(LONG_PH + 1);
    localparam logic [CNT_W-1:0] LIM_BLANK = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] LIM_WIN   = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] LIM_VDLY  = CNT_W'(VDLY_CYC);
    localparam logic [CNT_W-1:0] LIM_FLAT  = CNT_W'(FLAT_CYC);

    qrv_phase_e       phase_q;
    qrv_step_t        step;
    logic             flush;
    logic             done;
    logic             hit;
    logic [CNT_W-1:0] limit;
    logic             gate_q;
    logic             start_q;

    assign flush = rst_i | ~en_i;

    always_comb begin
        case (phase_q)
            PH_BLANK:  limit = LIM_BLANK;
            PH_SEARCH: limit = LIM_WIN;
            PH_VDLY:   limit = LIM_VDLY;
            PH_FLAT:   limit = LIM_FLAT;
            default:   limit = CNT_W'(1);
        endcase
    end

    qrv_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .flush_i   (flush),
        .restart_i (step.restart),
        .limit_i   (limit),
        .done_o    (done)
    );

    qrv_valley_det u_valley (
        .clk_i    (clk_i),
        .flush_i  (flush),
        .arm_i    (phase_q == PH_SEARCH),
        .cmp_i    (sync_cmp_i),
        .second_i (second_valley_i),
        .hit_o    (hit)
    );

    always_comb begin
        step = '{next: phase_q, restart: 1'b0, fire: 1'b0, start: 1'b0};
        case (phase_q)
            PH_IDLE: begin
                step.next    = PH_BLANK;
                step.restart = 1'b1;
                step.start   = 1'b1;
            end
            PH_BLANK: if (done) begin
                step.restart = 1'b1;
                step.next    = sync_high_i ? PH_FLAT : PH_SEARCH;
            end
            PH_SEARCH: begin
                if (hit) begin
                    step.next    = PH_VDLY;
                    step.restart = 1'b1;
                end else if (done) begin
                    step.fire = 1'b1;
                end
            end
            PH_VDLY, PH_FLAT: if (done) step.fire = 1'b1;
            default: step.next = PH_IDLE;
        endcase
        if (step.fire) begin
            step.next    = PH_BLANK;
            step.restart = 1'b1;
            step.start   = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (flush) begin
            phase_q <= PH_IDLE;
            gate_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            phase_q <= step.next;
            gate_q  <= step.fire;
            start_q <= step.start;
        end
    end

    assign gate_on_o     = gate_q;
    assign cycle_start_o = start_q;
endmodule

// File: rtl/qr_valley_timer_chk.sv
module qr_valley_timer_chk
    import qrv_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 15,
    parameter int unsigned WIN_CYC   = 6,
    parameter int unsigned VDLY_CYC  = 1,
    parameter int unsigned FLAT_CYC  = 2
) (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic gate_on_o,
    input logic cycle_start_o
);
    localparam int unsigned LONGEST = qrv_max(BLANK_CYC + WIN_CYC + VDLY_CYC,
                                              BLANK_CYC + FLAT_CYC);
    localparam int unsigned SW = $clog2(LONGEST + 2);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i)      since_q <= '0;
        else if (cycle_start_o)  since_q <= '0;
        else if (since_q != '1)  since_q <= since_q + 1'b1;
    end

    // R9
    gate_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_on_o |-> cycle_start_o);
    // R9
    gate_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_on_o |=> !gate_on_o);
    // R1
    hold_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!gate_on_o && !cycle_start_o));
    // R3
    blank_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_on_o |-> (since_q >= SW'(BLANK_CYC)));
    // R6
    max_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        since_q < SW'(LONGEST));
endmodule

bind qr_valley_timer qr_valley_timer_chk #(
    .BLANK_CYC (BLANK_CYC),
    .WIN_CYC   (WIN_CYC),
    .VDLY_CYC  (VDLY_CYC),
    .FLAT_CYC  (FLAT_CYC)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .en_i          (en_i),
    .gate_on_o     (gate_on_o),
    .cycle_start_o (cycle_start_o)
);

// File: tb/qr_valley_timer_tb.sv
module qr_valley_timer_tb;
    localparam int B = 15;
    localparam int W = 6;
    localparam int D = 1;
    localparam int F = 2;
    localparam int NONE = -100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic sync_hi = 1'b0;
    logic sync_cmp = 1'b1;
    logic sel = 1'b0;
    logic gate_on;
    logic cycle_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_start = 0;
    bit done = 1'b0;

    typedef struct {
        int    ivl;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qr_valley_timer #(.BLANK_CYC(B), .WIN_CYC(W), .VDLY_CYC(D), .FLAT_CYC(F)) u_dut (
        .clk_i           (clk),
        .rst_i           (rst),
        .en_i            (en),
        .sync_high_i     (sync_hi),
        .sync_cmp_i      (sync_cmp),
        .second_valley_i (sel),
        .gate_on_o       (gate_on),
        .cycle_start_o   (cycle_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected period lengths (0 = start pulse without gate)
    always @(negedge clk) begin
        if (!rst && (gate_on || cycle_start)) begin
            int act;
            exp_t it;
            act = gate_on ? (cyc - last_start) : 0;
            if (gate_on && !cycle_start)
                check(1'b0, "R9 gate without start", 1, 0);
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected pulse", act, -1);
            end else begin
                it = sb_q.pop_front();
                check(act == it.ivl, it.tag, act, it.ivl);
            end
            if (cycle_start) last_start = cyc;
        end
    end

    // driver: called at the negedge on which a period start is seen
    task automatic run_period(input int hi_last, input int ring_k, input int v1,
                              input int v2, input bit sel_v, input int exp, input string tag);
        sb_q.push_back('{exp, tag});
        sel = sel_v;
        for (int k = 1; k < 60; k++) begin
            sync_hi  = (k <= hi_last);
            sync_cmp = !((k == ring_k) || (k == B + v1) || (k == B + v2));
            @(negedge clk);
            if (cycle_start) break;
        end
        sync_cmp = 1'b1;
    endtask

    task automatic wait_start();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (cycle_start) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(gate_on == 1'b0 && cycle_start == 1'b0, "R1 reset outputs", gate_on + cycle_start, 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(gate_on == 1'b0 && cycle_start == 1'b0, "R1 disabled outputs", gate_on + cycle_start, 0);
        end
        sb_q.push_back('{0, "R2 first start without gate"});
        en = 1'b1;
        wait_start();

        run_period(4, NONE, 3, NONE, 1'b0, B + 3 + D, "R4 first valley j=3");
        run_period(4, NONE, NONE, NONE, 1'b0, B + W, "R6 forced turn-on");
        run_period(B, NONE, NONE, NONE, 1'b0, B + F, "R7 flat sync");
        run_period(4, 6, 1, NONE, 1'b0, B + 1 + D, "R5 blanking edge ignored");
        run_period(4, NONE, 1, 4, 1'b1, B + 4 + D, "R8 second valley");
        run_period(4, NONE, 2, NONE, 1'b1, B + W, "R8 single valley forced");
        run_period(4, NONE, W, NONE, 1'b0, B + W + D, "R10 valley on last window cycle");
        run_period(B, NONE, 1, NONE, 1'b0, B + F, "R7 flat ignores comparator");

        // abandon a period in mid-flight
        sync_hi = 1'b1;
        repeat (8) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(gate_on == 1'b0 && cycle_start == 1'b0, "R11 quiet while disabled", gate_on + cycle_start, 0);
        end
        sb_q.push_back('{0, "R11 restart pulse"});
        en = 1'b1;
        wait_start();
        run_period(4, NONE, NONE, NONE, 1'b0, B + W, "R11 fresh period forced");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R9 all expected pulses seen", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected 0 pending", sb_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule